// File: doc/BRIEF.md
# Pipelined Weighted Vector Adder

The block forms w = alpha·x + beta·y for one element pair at a time on a streamed vector. A host first loads the two scalar weights. It then presents (x, y) pairs with a valid strobe, at up to one pair per clock. Two independent multiplier lanes scale x by alpha and y by beta in parallel. Each lane raises its own done flag when its product is ready. An adder stage then joins the two products, and the sum leaves with a result strobe.

Operands are signed two's-complement fixed-point words of `DATA_W` bits that share one binary-point position. The result is exact: it is `2*DATA_W+1` bits wide and has twice the operand's fraction bits, so no rounding or saturation takes place. Both latencies are parameters. With the defaults, the products are ready 5 cycles after acceptance and the sum follows 4 cycles later, for 9 cycles in all. Successive elements overlap fully in the pipeline.

Top module: `wva_pipe`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, out_valid_o, alpha_done_o and beta_done_o are all 0.
- R2: When wload_i is 1 at a rising edge, alpha_i and beta_i become the active weights. When wload_i is 0, alpha_i and beta_i have no effect on any result.
- R3: Suppose a pair is accepted (in_valid_i is 1) in cycle c. Then alpha_done_o and beta_done_o are both 1 in cycle c+MUL_LAT (c+5 by default), and the two flags always assert in the same cycle.
- R4: For a pair accepted in cycle c, out_valid_o is 1 in cycle c+MUL_LAT+ADD_LAT (c+9 by default). In that cycle w_o holds alpha·x + beta·y as an exact signed value of 2*DATA_W+1 bits.
- R5: The block accepts a pair on every cycle. It produces exactly one result strobe per accepted pair, and the results leave in the order the pairs were accepted.
- R6: A weight load affects only pairs accepted in later cycles. A pair accepted in the same cycle as a load, or already in flight, uses the weights that were active before the load.
- R7: In a cycle where in_valid_i is 0, x_i and y_i are ignored, and no done flag or result strobe results from that cycle.
- R8: Results are exact at the signed extremes, including when every operand is the most negative value (-2^(DATA_W-1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wload_i | input | 1 | Load alpha_i and beta_i as the new weights |
| alpha_i | input | DATA_W | Weight applied to x |
| beta_i | input | DATA_W | Weight applied to y |
| in_valid_i | input | 1 | Element pair present on x_i and y_i |
| x_i | input | DATA_W | First vector element |
| y_i | input | DATA_W | Second vector element |
| alpha_done_o | output | 1 | alpha·x product ready for the pair in flight |
| beta_done_o | output | 1 | beta·y product ready for the pair in flight |
| out_valid_o | output | 1 | Result strobe |
| w_o | output | 2*DATA_W+1 | Weighted sum, exact |

## Verification
The assertions assume that the data inputs are driven to known values whenever in_valid_i or wload_i is high. The in-flight count check assumes that each accepted pair produces exactly one strobe. The bench drives every input from a defined value on the falling edge and never leaves x_i, y_i or the weights unknown. When it wants to show that an input is ignored, it toggles that input to nonzero data in cycles where the input must have no effect.

// File: rtl/wva_pkg.sv
package wva_pkg;
  localparam int unsigned DEF_DATA_W  = 16;
  localparam int unsigned DEF_MUL_LAT = 5;
  localparam int unsigned DEF_ADD_LAT = 4;

  function automatic int unsigned prod_w(input int unsigned dw);
    return 2 * dw;
  endfunction

  function automatic int unsigned sum_w(input int unsigned dw);
    return 2 * dw + 1;
  endfunction
endpackage

// File: rtl/wva_delay.sv
module wva_delay #(
  parameter int unsigned W   = 8,
  parameter int unsigned LAT = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         v_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);
  if (LAT == 0) begin : g_pass
    assign v_o = v_i;
    assign d_o = d_i;
  end else begin : g_pipe
    logic         v_q [LAT];
    logic [W-1:0] d_q [LAT];
    for (genvar s = 0; s < LAT; s++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[s] <= 1'b0;
          d_q[s] <= '0;
        end else if (s == 0) begin
          v_q[s] <= v_i;
          d_q[s] <= d_i;
        end else begin
          v_q[s] <= v_q[s-1];
          d_q[s] <= d_q[s-1];
        end
      end
    end
    assign v_o = v_q[LAT-1];
    assign d_o = d_q[LAT-1];
  end
endmodule

// File: rtl/wva_mul_lane.sv
module wva_mul_lane #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LAT    = 5,
  localparam int unsigned PW    = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wgt_i,
  input  logic              v_i,
  input  logic [DATA_W-1:0] x_i,
  output logic              done_o,
  output logic [PW-1:0]     prod_o
);
  logic signed [DATA_W-1:0] wgt_q, w1_q, x1_q;
  logic                     v1_q;
  logic signed [PW-1:0]     prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wgt_q <= '0;
    else if (load_i) wgt_q <= wgt_i;
  end

  // operand capture: weight taken before any same-cycle load lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      x1_q <= '0;
      w1_q <= '0;
    end else begin
      v1_q <= v_i;
      if (v_i) begin
        x1_q <= x_i;
        w1_q <= wgt_q;
      end
    end
  end

  assign prod = PW'(x1_q) * PW'(w1_q);

  wva_delay #(.W(PW), .LAT(LAT - 1)) u_mdly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (v1_q),
    .d_i   (prod),
    .v_o   (done_o),
    .d_o   (prod_o)
  );

  // R3
  prod_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$isunknown(prod_o));
endmodule

// File: rtl/wva_add_stage.sv
module wva_add_stage #(
  parameter int unsigned IN_W = 32,
  parameter int unsigned LAT  = 4,
  localparam int unsigned OW  = IN_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            v_i,
  input  logic [IN_W-1:0] a_i,
  input  logic [IN_W-1:0] b_i,
  output logic            v_o,
  output logic [OW-1:0]   s_o
);
  logic signed [OW-1:0] sum;

  assign sum = OW'($signed(a_i)) + OW'($signed(b_i));

  wva_delay #(.W(OW), .LAT(LAT)) u_adly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (v_i),
    .d_i   (sum),
    .v_o   (v_o),
    .d_o   (s_o)
  );

  // R4
  sum_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> !$isunknown(s_o));
endmodule

// File: rtl/wva_pipe.sv
module wva_pipe
  import wva_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned MUL_LAT = DEF_MUL_LAT,
  parameter int unsigned ADD_LAT = DEF_ADD_LAT,
  localparam int unsigned PW     = prod_w(DATA_W),
  localparam int unsigned SW     = sum_w(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wload_i,
  input  logic [DATA_W-1:0] alpha_i,
  input  logic [DATA_W-1:0] beta_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic              alpha_done_o,
  output logic              beta_done_o,
  output logic              out_valid_o,
  output logic [SW-1:0]     w_o
);
  logic [PW-1:0] a_prod, b_prod;

  wva_mul_lane #(.DATA_W(DATA_W), .LAT(MUL_LAT)) u_alpha (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wload_i),
    .wgt_i (alpha_i),
    .v_i   (in_valid_i),
    .x_i   (x_i),
    .done_o(alpha_done_o),
    .prod_o(a_prod)
  );

  wva_mul_lane #(.DATA_W(DATA_W), .LAT(MUL_LAT)) u_beta (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wload_i),
    .wgt_i (beta_i),
    .v_i   (in_valid_i),
    .x_i   (y_i),
    .done_o(beta_done_o),
    .prod_o(b_prod)
  );

  // join: add only once both lanes report done
  wva_add_stage #(.IN_W(PW), .LAT(ADD_LAT)) u_add (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (alpha_done_o & beta_done_o),
    .a_i   (a_prod),
    .b_i   (b_prod),
    .v_o   (out_valid_o),
    .s_o   (w_o)
  );

  // in-flight occupancy tracker for the checks below
  localparam int unsigned DEPTH = MUL_LAT + ADD_LAT;
  localparam int unsigned CW    = $clog2(DEPTH + 2);
  logic [CW-1:0] inflight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else begin
      case ({in_valid_i, out_valid_o})
        2'b10:   inflight_q <= inflight_q + 1'b1;
        2'b01:   inflight_q <= inflight_q - 1'b1;
        default: inflight_q <= inflight_q;
      endcase
    end
  end

  // R3
  done_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alpha_done_o == beta_done_o);

  // R5
  inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CW'(DEPTH));

  // R5
  strobe_has_elem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> inflight_q != '0);

  // R7
  done_has_elem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alpha_done_o |-> inflight_q != '0);
endmodule

// File: tb/sim_wva_pipe.sv
module sim_wva_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int SW  = 2 * DW + 1;
  localparam int MLAT = 5;
  localparam int ALAT = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wload_i = 1'b0;
  logic [DW-1:0] alpha_i = '0, beta_i = '0, x_i = '0, y_i = '0;
  logic in_valid_i = 1'b0;
  logic alpha_done_o, beta_done_o, out_valid_o;
  logic [SW-1:0] w_o;

  int total = 0, bad = 0, cyc = 0;
  bit mon_en = 1'b0;
  logic signed [DW-1:0] m_a = '0, m_b = '0;
  logic [SW-1:0] exp_w[$];
  int exp_t[$], exp_d[$];
  string exp_r[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wva_pipe u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wload_i(wload_i), .alpha_i(alpha_i),
    .beta_i(beta_i), .in_valid_i(in_valid_i), .x_i(x_i), .y_i(y_i),
    .alpha_done_o(alpha_done_o), .beta_done_o(beta_done_o),
    .out_valid_o(out_valid_o), .w_o(w_o)
  );

  task automatic chk(bit ok, string r, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, expv);
    end
  endtask

  // per-cycle monitor: strobes and values against the model queues
  always @(negedge clk) if (mon_en) begin
    bit d_exp, v_exp;
    d_exp = (exp_d.size() != 0) && (exp_d[0] == cyc);
    if (d_exp) void'(exp_d.pop_front());
    chk(alpha_done_o == d_exp && beta_done_o == d_exp, "R3", "done flags",
        {alpha_done_o, beta_done_o}, {d_exp, d_exp});
    v_exp = (exp_t.size() != 0) && (exp_t[0] == cyc);
    chk(out_valid_o == v_exp, v_exp ? exp_r[0] : "R7", "out_valid", out_valid_o, v_exp);
    if (v_exp) begin
      chk(w_o == exp_w[0], exp_r[0], "w_o", $signed(w_o), $signed(exp_w[0]));
      void'(exp_t.pop_front()); void'(exp_w.pop_front()); void'(exp_r.pop_front());
    end
  end

  task automatic drive(bit v, logic signed [DW-1:0] x, logic signed [DW-1:0] y,
                       bit ld, logic signed [DW-1:0] a, logic signed [DW-1:0] b, string r);
    longint e;
    in_valid_i = v; x_i = x; y_i = y; wload_i = ld; alpha_i = a; beta_i = b;
    if (v) begin
      e = longint'(m_a) * longint'(x) + longint'(m_b) * longint'(y);
      exp_w.push_back(SW'(e));
      exp_t.push_back(cyc + MLAT + ALAT);
      exp_d.push_back(cyc + MLAT);
      exp_r.push_back(r);
    end
    if (ld) begin m_a = a; m_b = b; end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 16'sh5A5A, -16'sd77, 1'b0, 16'sh1234, -16'sd3, "R7");
  endtask

  task automatic drain(string r);
    idle(MLAT + ALAT + 3);
    chk(exp_t.size() == 0 && exp_d.size() == 0, r, "pending results", exp_t.size(), 0);
  endtask

  task automatic t_reset;
    #(CLK_PERIOD * 2 + 1);
    chk(!out_valid_o && !alpha_done_o && !beta_done_o, "R1", "in reset",
        {out_valid_o, alpha_done_o, beta_done_o}, 0);
    @(negedge clk); rst_ni = 1'b1; mon_en = 1'b1;
    @(negedge clk);
    chk(!out_valid_o && !alpha_done_o, "R1", "after release", {out_valid_o, alpha_done_o}, 0);
  endtask

  task automatic t_single;
    drive(1'b0, 0, 0, 1'b1, 16'sh0380, -16'sh0140, "R2");
    drive(1'b1, 16'sh0200, -16'sh0A80, 1'b0, 0, 0, "R4");
    drain("R4");
  endtask

  task automatic t_hold;
    drive(1'b0, 0, 0, 1'b1, 16'sd7, -16'sd11, "R2");
    for (int i = 0; i < 4; i++)
      drive(1'b1, 16'(i * 300 - 500), 16'(i * 41 + 3), 1'b0, 16'sd999, 16'sd888, "R2");
    drain("R2");
  endtask

  task automatic t_stream;
    drive(1'b0, 0, 0, 1'b1, 16'($urandom), 16'($urandom), "R5");
    for (int i = 0; i < 24; i++) drive(1'b1, 16'($urandom), 16'($urandom), 1'b0, 0, 0, "R5");
    drain("R5");
  endtask

  task automatic t_reload;
    drive(1'b0, 0, 0, 1'b1, 16'sd5, 16'sd9, "R6");
    for (int i = 0; i < 12; i++) begin
      bit ld = (i == 3) || (i == 7) || (i == 8);
      drive(1'b1, 16'(i * 1000 - 6000), 16'(2500 - i * 333), ld,
            16'(i * 17 - 40), 16'(-i * 5 + 2), "R6");
    end
    drain("R6");
  endtask

  task automatic t_gaps;
    drive(1'b0, 0, 0, 1'b1, -16'sd300, 16'sd123, "R7");
    for (int i = 0; i < 10; i++)
      drive(i % 3 != 1, 16'($urandom), 16'($urandom), 1'b0, 0, 0, "R7");
    drain("R7");
  endtask

  task automatic t_extreme;
    drive(1'b0, 0, 0, 1'b1, -16'sd32768, -16'sd32768, "R8");
    drive(1'b1, -16'sd32768, -16'sd32768, 1'b0, 0, 0, "R8");
    drive(1'b1, 16'sd32767, 16'sd32767, 1'b1, -16'sd32768, 16'sd32767, "R8");
    drive(1'b1, 16'sd32767, -16'sd32768, 1'b0, 0, 0, "R8");
    drain("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_single;
    t_hold;
    t_stream;
    t_reload;
    t_gaps;
    t_extreme;
    mon_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule